// File: doc/BRIEF.md
# Depth-Reconfigurable Router Flit Pipeline

This block carries flits from one router input to one output link through the four logical steps of a virtual-channel router: buffer write with route computation, output VC allocation, switch allocation and switch traversal. The order of the steps never changes. What changes is how many of the inter-step registers are in use. Two-to-one multiplexers can bypass the first three registers, so the whole path occupies 4, 3, 2 or 1 register stages. The register after switch traversal is always kept. When the router clock is slowed against the cores, a shallower setting keeps the latency of a flit, measured in core time, close to its full-speed value.

The depth is configured statically. A configuration request gives either an explicit depth or a router-to-core clock ratio, which a small chooser turns into a depth. A request is held pending while any flit is inside the pipeline, and no new flit is accepted until the pipeline has drained and the new depth has taken effect. A single-requester switch allocator raises a request for the flit at the switch allocation step. It advances that flit only when the external grant is high. Without a grant the flit and everything behind it wait in place.

Top module: `flex_flit_pipe`

## Requirements
- R1: After reset, out_valid and sw_req are 0, in_ready is 1 and cur_depth is 4.
- R2: With sw_grant held high, a flit accepted in cycle c is on the output in cycle c+N, where N is cur_depth (4, 3, 2 or 1).
- R3: The register after switch allocation is bypassed at depth 3 or less, the register after VC allocation at depth 2 or less, and the register after route computation at depth 1. So sw_req for a flit accepted in cycle c rises in cycle c+2 at depth 4 or 3, c+1 at depth 2 and c at depth 1.
- R4: Head flits (kind 2'b01) and single-flit packets (kind 2'b11) get an output port from XY routing. The destination is dest[1:0]=x and dest[3:2]=y, and the router sits at (1,1). A larger x gives port 1, a smaller x gives port 2. With equal x, a larger y gives port 3 and a smaller y gives port 4. Equal coordinates give port 0. Body (2'b00) and tail (2'b10) flits carry their head's port whatever their own dest field holds.
- R5: Each head or single-flit packet gets output VC 0, 1, 2, 3, 0, … in acceptance order. Body and tail flits carry their head's VC.
- R6: With cfg_auto=1, a load maps clock ratio 0 or 1 to depth 4, ratio 2 or 3 to depth 2, and ratio 4 to 7 to depth 1.
- R7: With cfg_auto=0, a load sets depth cfg_depth if it is 1 to 4. Any other value is ignored: depth stays, and in_ready does not drop.
- R8: The depth changes only at an edge where no stage register holds a flit. From the cycle after a load until the new depth is in effect, in_ready is 0.
- R9: While sw_grant is low, the flit at switch allocation and the flits behind it stay in place, and in_ready drops once the registers ahead are full. When the grant returns, every flit leaves once and in order.
- R10: With sw_grant high, flits offered back to back leave on consecutive cycles at every depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Flit offered at the input |
| in_ready | output | 1 | Flit accepted at this edge when in_valid is high |
| in_kind | input | 2 | 00 body, 01 head, 10 tail, 11 single-flit packet |
| in_dest | input | 4 | Destination node, y in [3:2], x in [1:0] |
| in_data | input | 16 | Flit payload |
| sw_req | output | 1 | Switch request for the flit at switch allocation |
| sw_grant | input | 1 | Switch grant from the arbiter |
| out_valid | output | 1 | Flit on the output link |
| out_kind | output | 2 | Kind of the output flit |
| out_port | output | 3 | Output port chosen by routing |
| out_vc | output | 2 | Output VC chosen by allocation |
| out_data | output | 16 | Payload of the output flit |
| cfg_load | input | 1 | Configuration request strobe |
| cfg_auto | input | 1 | 1: derive depth from cfg_ratio, 0: use cfg_depth |
| cfg_depth | input | 3 | Explicit depth, 1 to 4 |
| cfg_ratio | input | 3 | Router-to-core clock ratio |
| cur_depth | output | 3 | Depth in effect |

## Verification
Single flits are sent at each of the four depths, and both their output cycle and their switch-request cycle are timed. The two timings together show which registers were merged, which the end-to-end latency alone does not. Multi-flit packets with garbage dest fields in their body flits tell true port and VC inheritance apart from per-flit recomputation, and their back-to-back timing exposes lost throughput. A stalled burst with a withheld grant separates correct back-pressure from loss, duplication or reordering. A configuration request issued behind a stuck flit shows whether the depth waits for the drain. Ratio sweeps and illegal explicit depths cover the chooser.

// File: rtl/flex_pipe_pkg.sv
package flex_pipe_pkg;

    localparam int DATA_W    = 16;
    localparam int NODE_W    = 4;
    localparam int COORD_W   = NODE_W / 2;
    localparam int VC_W      = 2;
    localparam int PORT_W    = 3;
    localparam int DEPTH_W   = 3;
    localparam int RATIO_W   = 3;
    localparam int NUM_STEPS = 4;

    typedef enum logic [1:0] {
        FK_BODY = 2'b00,
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_e;

    typedef enum logic [PORT_W-1:0] {
        PT_LOCAL = 3'd0,
        PT_EAST  = 3'd1,
        PT_WEST  = 3'd2,
        PT_NORTH = 3'd3,
        PT_SOUTH = 3'd4
    } port_e;

    typedef struct packed {
        flit_kind_e          kind;
        logic [NODE_W-1:0]   dest;
        logic [DATA_W-1:0]   data;
        port_e               port;
        logic [VC_W-1:0]     vc;
    } flit_t;

    function automatic logic opens_packet(input flit_kind_e k);
        return (k == FK_HEAD) || (k == FK_SOLO);
    endfunction

    // Dimension-ordered routing: x first, then y.
    function automatic port_e xy_route(input logic [NODE_W-1:0] d, input int mx, input int my);
        int dx;
        int dy;
        dx = int'(d[COORD_W-1:0]);
        dy = int'(d[NODE_W-1:COORD_W]);
        if (dx > mx)      return PT_EAST;
        else if (dx < mx) return PT_WEST;
        else if (dy > my) return PT_NORTH;
        else if (dy < my) return PT_SOUTH;
        else              return PT_LOCAL;
    endfunction

    // Router-to-core clock ratio to register depth.
    function automatic logic [DEPTH_W-1:0] ratio_to_depth(input logic [RATIO_W-1:0] r);
        if (r <= RATIO_W'(1))      return DEPTH_W'(4);
        else if (r <= RATIO_W'(3)) return DEPTH_W'(2);
        else                       return DEPTH_W'(1);
    endfunction

endpackage

// File: rtl/flex_route_step.sv
module flex_route_step
    import flex_pipe_pkg::*;
#(
    parameter int MY_X = 1,
    parameter int MY_Y = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  flit_t in_flit,
    output flit_t out_flit
);
    port_e held_q;
    port_e fresh;

    always_comb begin
        fresh    = xy_route(in_flit.dest, MY_X, MY_Y);
        out_flit = in_flit;
        out_flit.port = opens_packet(in_flit.kind) ? fresh : held_q;
    end

    // The head's port is kept for the rest of its packet.
    always_ff @(posedge clk) begin
        if (rst)
            held_q <= PT_LOCAL;
        else if (fire && opens_packet(in_flit.kind))
            held_q <= fresh;
    end
endmodule

// File: rtl/flex_vc_step.sv
module flex_vc_step
    import flex_pipe_pkg::*;
#(
    parameter int NUM_VC = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  flit_t in_flit,
    output flit_t out_flit
);
    localparam logic [VC_W-1:0] LAST_VC = VC_W'(NUM_VC - 1);

    logic [VC_W-1:0] next_q;
    logic [VC_W-1:0] held_q;
    logic            is_head;

    always_comb begin
        is_head  = opens_packet(in_flit.kind);
        out_flit = in_flit;
        out_flit.vc = is_head ? next_q : held_q;
    end

    // Single-requester allocator: one free VC offered per head, in rotation.
    always_ff @(posedge clk) begin
        if (rst) begin
            next_q <= '0;
            held_q <= '0;
        end else if (fire && is_head) begin
            held_q <= next_q;
            next_q <= (next_q == LAST_VC) ? '0 : next_q + 1'b1;
        end
    end
endmodule

// File: rtl/flex_stage.sv
module flex_stage
    import flex_pipe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bypass,
    input  logic  gate,
    input  logic  up_valid,
    input  flit_t up_flit,
    input  logic  down_ready,
    output logic  up_ready,
    output logic  dn_valid,
    output flit_t dn_flit,
    output logic  held
);
    logic  v_q;
    flit_t f_q;

    assign up_ready = gate && (bypass ? down_ready : (!v_q || down_ready));
    assign dn_valid = bypass ? (up_valid && gate) : v_q;
    assign dn_flit  = bypass ? up_flit : f_q;
    assign held     = v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            f_q <= '0;
        end else if (bypass) begin
            v_q <= 1'b0;
        end else if (!v_q || down_ready) begin
            v_q <= up_valid && gate;
            if (up_valid && gate)
                f_q <= up_flit;
        end
    end
endmodule

// File: rtl/flex_depth_ctrl.sv
module flex_depth_ctrl
    import flex_pipe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load,
    input  logic               cfg_auto,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               pipe_empty,
    output logic [DEPTH_W-1:0] depth,
    output logic               pending
);
    localparam logic [DEPTH_W-1:0] FULL_DEPTH = DEPTH_W'(NUM_STEPS);

    logic [DEPTH_W-1:0] depth_q;
    logic [DEPTH_W-1:0] tgt_q;
    logic               pend_q;
    logic [DEPTH_W-1:0] req_depth;
    logic               req_ok;

    always_comb begin
        req_depth = cfg_auto ? ratio_to_depth(cfg_ratio) : cfg_depth;
        req_ok    = cfg_auto || ((cfg_depth != '0) && (cfg_depth <= FULL_DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= FULL_DEPTH;
            tgt_q   <= FULL_DEPTH;
            pend_q  <= 1'b0;
        end else if (cfg_load && req_ok) begin
            pend_q <= 1'b1;
            tgt_q  <= req_depth;
        end else if (pend_q && pipe_empty) begin
            depth_q <= tgt_q;
            pend_q  <= 1'b0;
        end
    end

    assign depth   = depth_q;
    assign pending = pend_q;
endmodule

// File: rtl/flex_flit_pipe.sv
module flex_flit_pipe
    import flex_pipe_pkg::*;
#(
    parameter int MY_X   = 1,
    parameter int MY_Y   = 1,
    parameter int NUM_VC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_kind,
    input  logic [NODE_W-1:0]  in_dest,
    input  logic [DATA_W-1:0]  in_data,
    output logic               sw_req,
    input  logic               sw_grant,
    output logic               out_valid,
    output logic [1:0]         out_kind,
    output logic [PORT_W-1:0]  out_port,
    output logic [VC_W-1:0]    out_vc,
    output logic [DATA_W-1:0]  out_data,
    input  logic               cfg_load,
    input  logic               cfg_auto,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic [RATIO_W-1:0] cfg_ratio,
    output logic [DEPTH_W-1:0] cur_depth
);
    localparam int RC_STEP = 0;
    localparam int VA_STEP = 1;
    localparam int SA_STEP = 2;
    localparam int LAST    = NUM_STEPS - 1;

    logic [NUM_STEPS:0]   s_vld;
    logic [NUM_STEPS:0]   s_rdy;
    flit_t                s_flit   [NUM_STEPS+1];
    flit_t                stp_flit [NUM_STEPS];
    logic [NUM_STEPS-1:0] bypass;
    logic [NUM_STEPS-1:0] gate;
    logic [NUM_STEPS-1:0] held;
    logic                 pending;
    logic                 pipe_empty;
    flit_t                entry_flit;

    always_comb begin
        entry_flit      = '0;
        entry_flit.kind = flit_kind_e'(in_kind);
        entry_flit.dest = in_dest;
        entry_flit.data = in_data;
    end

    assign s_vld[0]         = in_valid && !pending;
    assign s_flit[0]        = entry_flit;
    assign in_ready         = s_rdy[0] && !pending;
    assign s_rdy[NUM_STEPS] = 1'b1;
    assign pipe_empty       = ~|held;

    flex_depth_ctrl u_depth (
        .clk        (clk),
        .rst        (rst),
        .cfg_load   (cfg_load),
        .cfg_auto   (cfg_auto),
        .cfg_depth  (cfg_depth),
        .cfg_ratio  (cfg_ratio),
        .pipe_empty (pipe_empty),
        .depth      (cur_depth),
        .pending    (pending)
    );

    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
        // The register after the last step is never bypassed.
        if (k == LAST) begin : g_keep
            assign bypass[k] = 1'b0;
        end else begin : g_mux
            assign bypass[k] = (cur_depth <= DEPTH_W'(k + 1));
        end

        if (k == SA_STEP) begin : g_sa_gate
            assign gate[k] = sw_grant;
        end else begin : g_free
            assign gate[k] = 1'b1;
        end

        if (k == RC_STEP) begin : g_rc
            flex_route_step #(.MY_X(MY_X), .MY_Y(MY_Y)) u_rc (
                .clk      (clk),
                .rst      (rst),
                .fire     (s_vld[k] && s_rdy[k]),
                .in_flit  (s_flit[k]),
                .out_flit (stp_flit[k])
            );
        end else if (k == VA_STEP) begin : g_va
            flex_vc_step #(.NUM_VC(NUM_VC)) u_va (
                .clk      (clk),
                .rst      (rst),
                .fire     (s_vld[k] && s_rdy[k]),
                .in_flit  (s_flit[k]),
                .out_flit (stp_flit[k])
            );
        end else begin : g_pass
            assign stp_flit[k] = s_flit[k];
        end

        flex_stage u_stage (
            .clk        (clk),
            .rst        (rst),
            .bypass     (bypass[k]),
            .gate       (gate[k]),
            .up_valid   (s_vld[k]),
            .up_flit    (stp_flit[k]),
            .down_ready (s_rdy[k+1]),
            .up_ready   (s_rdy[k]),
            .dn_valid   (s_vld[k+1]),
            .dn_flit    (s_flit[k+1]),
            .held       (held[k])
        );
    end

    assign sw_req    = s_vld[SA_STEP];
    assign out_valid = s_vld[NUM_STEPS];
    assign out_kind  = s_flit[NUM_STEPS].kind;
    assign out_port  = s_flit[NUM_STEPS].port;
    assign out_vc    = s_flit[NUM_STEPS].vc;
    assign out_data  = s_flit[NUM_STEPS].data;
endmodule

// File: rtl/flex_flit_pipe_chk.sv
module flex_flit_pipe_chk
    import flex_pipe_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               sw_req,
    input logic               sw_grant,
    input logic               out_valid,
    input logic [1:0]         out_kind,
    input logic [VC_W-1:0]    out_vc,
    input logic [DEPTH_W-1:0] cur_depth,
    input logic               pipe_empty
);
    logic [VC_W-1:0] last_head_vc;

    always_ff @(posedge clk) begin
        if (rst)
            last_head_vc <= '0;
        else if (out_valid && out_kind[0])
            last_head_vc <= out_vc;
    end

    a_r2_depth_legal: assert property (@(posedge clk) disable iff (rst)
        (cur_depth >= DEPTH_W'(1)) && (cur_depth <= DEPTH_W'(NUM_STEPS)));

    a_r8_change_when_empty: assert property (@(posedge clk) disable iff (rst)
        (cur_depth != $past(cur_depth)) |-> $past(pipe_empty));

    a_r9_stall_keeps_req: assert property (@(posedge clk) disable iff (rst)
        (cur_depth != DEPTH_W'(1)) && sw_req && !sw_grant |=> sw_req);

    a_r2_single_stage_latency: assert property (@(posedge clk) disable iff (rst)
        (cur_depth == DEPTH_W'(1)) && in_valid && in_ready |=> out_valid);

    a_r5_body_inherits_vc: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_kind[0] |-> out_vc == last_head_vc);
endmodule

bind flex_flit_pipe flex_flit_pipe_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .sw_req     (sw_req),
    .sw_grant   (sw_grant),
    .out_valid  (out_valid),
    .out_kind   (out_kind),
    .out_vc     (out_vc),
    .cur_depth  (cur_depth),
    .pipe_empty (pipe_empty)
);

// File: tb/test_flex_flit_pipe.sv
module test_flex_flit_pipe;
    import flex_pipe_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic               in_ready;
    logic [1:0]         in_kind;
    logic [NODE_W-1:0]  in_dest;
    logic [DATA_W-1:0]  in_data;
    logic               sw_req;
    logic               sw_grant;
    logic               out_valid;
    logic [1:0]         out_kind;
    logic [PORT_W-1:0]  out_port;
    logic [VC_W-1:0]    out_vc;
    logic [DATA_W-1:0]  out_data;
    logic               cfg_load;
    logic               cfg_auto;
    logic [DEPTH_W-1:0] cfg_depth;
    logic [RATIO_W-1:0] cfg_ratio;
    logic [DEPTH_W-1:0] cur_depth;

    int checks   = 0;
    int failures = 0;
    int exp_vc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flex_flit_pipe i_flex_flit_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_kind   (in_kind),
        .in_dest   (in_dest),
        .in_data   (in_data),
        .sw_req    (sw_req),
        .sw_grant  (sw_grant),
        .out_valid (out_valid),
        .out_kind  (out_kind),
        .out_port  (out_port),
        .out_vc    (out_vc),
        .out_data  (out_data),
        .cfg_load  (cfg_load),
        .cfg_auto  (cfg_auto),
        .cfg_depth (cfg_depth),
        .cfg_ratio (cfg_ratio),
        .cur_depth (cur_depth)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_request(input logic auto_sel, input int dval, input int rval);
        @(negedge clk);
        cfg_load  = 1'b1;
        cfg_auto  = auto_sel;
        cfg_depth = DEPTH_W'(dval);
        cfg_ratio = RATIO_W'(rval);
        @(negedge clk);
        cfg_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_depth(input int d);
        cfg_request(1'b0, d, 0);
        chk("R7", "explicit depth", int'(cur_depth), d);
    endtask

    // R1: reset values
    task automatic t_reset;
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "sw_req", int'(sw_req), 0);
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "cur_depth", int'(cur_depth), 4);
    endtask

    // R2, R3, R4: one single-flit packet, timed through the pipeline
    task automatic t_latency(input int d, input int dest, input int port, input int req_off);
        int out_at = -1;
        int req_at = -1;
        set_depth(d);
        sw_grant = 1'b1;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            in_valid = (j == 0);
            in_kind  = 2'b11;
            in_dest  = NODE_W'(dest);
            in_data  = DATA_W'(16'hA000 + d);
            #1;
            if (j == 0) chk("R2", "in_ready at entry", int'(in_ready), 1);
            if (sw_req && req_at < 0) req_at = j;
            if (out_valid && out_at < 0) begin
                out_at = j;
                chk("R4", "routed port", int'(out_port), port);
                chk("R5", "solo vc", int'(out_vc), exp_vc);
                chk("R2", "payload", int'(out_data), 16'hA000 + d);
            end
        end
        exp_vc = (exp_vc + 1) % 4;
        chk("R2", "latency cycles", out_at, d);
        chk("R3", "switch request cycle", req_at, req_off);
    endtask

    // R4, R5, R10: back-to-back packet, body dest fields set to junk
    task automatic t_packet(input int d, input int dest, input int port, input int nbody);
        int total = nbody + 2;
        int idx   = 0;
        int base  = 16'h5000 + d * 16;
        set_depth(d);
        sw_grant = 1'b1;
        for (int j = 0; j < d + total + 3; j++) begin
            @(negedge clk);
            in_valid = (j < total);
            in_kind  = (j == 0) ? 2'b01 : ((j == total - 1) ? 2'b10 : 2'b00);
            in_dest  = (j == 0) ? NODE_W'(dest) : NODE_W'(j * 5);
            in_data  = DATA_W'(base + j);
            #1;
            if (j < total) chk("R10", "in_ready back to back", int'(in_ready), 1);
            if (out_valid) begin
                chk("R10", "consecutive output cycle", j, d + idx);
                chk("R10", "payload order", int'(out_data), base + idx);
                chk("R4", "port inherited", int'(out_port), port);
                chk("R5", "vc inherited", int'(out_vc), exp_vc);
                idx++;
            end
        end
        exp_vc = (exp_vc + 1) % 4;
        chk("R10", "flits out", idx, total);
    endtask

    // R9: withheld grant, burst must survive intact
    task automatic t_stall;
        int n      = 6;
        int sent   = 0;
        int got    = 0;
        int bad    = 0;
        int blocked = 0;
        int base   = 16'h7700;
        set_depth(4);
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            sw_grant = (j >= 8);
            in_valid = (sent < n);
            in_kind  = (sent == 0) ? 2'b01 : ((sent == n - 1) ? 2'b10 : 2'b00);
            in_dest  = 4'b0111;
            in_data  = DATA_W'(base + sent);
            #1;
            if (out_valid) begin
                if (int'(out_data) != base + got) bad++;
                got++;
            end
            if (in_valid && !in_ready) blocked = 1;
            if (in_valid && in_ready) sent++;
        end
        in_valid = 1'b0;
        exp_vc = (exp_vc + 1) % 4;
        chk("R9", "in_ready dropped while stalled", blocked, 1);
        chk("R9", "flits delivered", got, n);
        chk("R9", "out-of-order or duplicate flits", bad, 0);
    endtask

    // R8: depth request behind a stuck flit waits for the drain
    task automatic t_drain_change;
        int out_at = -1;
        int dep_at = -1;
        set_depth(4);
        @(negedge clk);
        sw_grant = 1'b0;
        in_valid = 1'b1;
        in_kind  = 2'b11;
        in_dest  = 4'b0101;
        in_data  = 16'hD00D;
        @(negedge clk);
        in_valid  = 1'b0;
        cfg_load  = 1'b1;
        cfg_auto  = 1'b0;
        cfg_depth = 3'd2;
        @(negedge clk);
        cfg_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R8", "in_ready while pending", int'(in_ready), 0);
        chk("R8", "depth held while flit in flight", int'(cur_depth), 4);
        for (int j = 0; j < 15; j++) begin
            @(negedge clk);
            sw_grant = 1'b1;
            #1;
            if (out_valid && out_at < 0) out_at = j;
            if (cur_depth == 3'd2 && dep_at < 0) dep_at = j;
        end
        exp_vc = (exp_vc + 1) % 4;
        chk("R8", "stuck flit delivered", int'(out_at >= 0), 1);
        chk("R8", "depth changed after drain", int'(dep_at > out_at), 1);
        chk("R8", "in_ready restored", int'(in_ready), 1);
    endtask

    // R6: ratio chooser sweep
    task automatic t_ratio;
        for (int r = 0; r < 8; r++) begin
            int want;
            want = (r <= 1) ? 4 : ((r <= 3) ? 2 : 1);
            cfg_request(1'b1, 0, r);
            chk("R6", $sformatf("depth for ratio %0d", r), int'(cur_depth), want);
        end
    endtask

    // R7: out-of-range explicit depths are ignored
    task automatic t_illegal;
        set_depth(2);
        for (int v = 0; v < 8; v++) begin
            if (v == 0 || v > 4) begin
                @(negedge clk);
                cfg_load  = 1'b1;
                cfg_auto  = 1'b0;
                cfg_depth = DEPTH_W'(v);
                @(negedge clk);
                cfg_load = 1'b0;
                #1;
                chk("R7", $sformatf("in_ready after illegal %0d", v), int'(in_ready), 1);
                @(negedge clk);
                chk("R7", $sformatf("depth after illegal %0d", v), int'(cur_depth), 2);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_kind   = 2'b00;
        in_dest   = '0;
        in_data   = '0;
        sw_grant  = 1'b0;
        cfg_load  = 1'b0;
        cfg_auto  = 1'b0;
        cfg_depth = '0;
        cfg_ratio = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        t_reset();
        t_latency(4, 4'b0111, 1, 2);
        t_latency(3, 4'b0100, 2, 2);
        t_latency(2, 4'b1101, 3, 1);
        t_latency(1, 4'b0001, 4, 0);
        t_packet(4, 4'b0101, 0, 3);
        t_packet(1, 4'b0111, 1, 2);
        t_packet(2, 4'b0001, 4, 1);
        t_stall();
        t_drain_change();
        t_ratio();
        t_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule